// File: doc/BRIEF.md
# Display Mode Sequencer with Status Register

This block generates scanline and frame timing for a tile-based LCD controller. A dot counter steps through each line of 456 dots, and a line counter steps through 154 lines per frame. From these two counters the block derives one of four display modes: attribute search, pixel transfer, horizontal blank or vertical blank. It also drives two access-block outputs. These tell the memory arbiter when the CPU must be kept away from video RAM or sprite attribute RAM.

The CPU reaches the block through a small register port with two registers: a status register and a compare-line register. A status read merges the live mode and the live line-compare result with the interrupt-enable bits that the CPU wrote earlier. Bit 7 of that read is always 1. A status write changes only the enable bits. The enabled conditions are ORed together, and a one-cycle status interrupt request is raised on each rising edge of that OR.

Counting advances only on cycles where the dot enable is high. While the LCD enable is low, both counters are cleared and held.

Top module: `lms_mode_seq`

## Requirements
- R1: On lines 0 to 143, dots 0 to 79 are in mode 2 (attribute search), dots 80 to 251 are in mode 3 (pixel transfer), and dots 252 to 455 are in mode 0 (horizontal blank).
- R2: A line has 456 dots and a frame has 154 lines. Lines 144 to 153 are in mode 1 (vertical blank) for the whole line. After the last dot of line 153, the line counter returns to 0 and the mode returns to 2.
- R3: Status register (reg_sel = 0) bits 1:0 read the current mode: 0 = horizontal blank, 1 = vertical blank, 2 = attribute search, 3 = pixel transfer.
- R4: Status bit 2 reads 1 exactly when line_cnt equals the compare-line register, and 0 otherwise.
- R5: Status bits 3, 4, 5 and 6 are the interrupt enables for horizontal blank, vertical blank, attribute search and line match, in that order. A status write stores wdata bits 6:3 and cannot change bits 7 or 2:0. Bit 7 always reads 1. All four enables are 0 after reset.
- R6: oam_block is 1 in modes 2 and 3. vram_block is 1 only in mode 3. Both are 0 in modes 0 and 1.
- R7: When lcd_on rises, the sequencer starts at line 0, dot 0, in mode 2.
- R8: While lcd_on is low, line_cnt reads 0, mode reads 0 and neither block output is asserted.
- R9: stat_irq is a single-cycle pulse. It is raised in the cycle after the OR of the enabled conditions goes from 0 to 1. The conditions are: mode 0 with bit 3 set, mode 1 with bit 4 set, mode 2 with bit 5 set, and line match with bit 6 set. A condition that stays true raises no further pulse.
- R10: In a cycle where dot_en is low, neither the dot counter nor the line counter advances.
- R11: The compare-line register (reg_sel = 1) is written with all 8 bits of wdata and reads back unchanged. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_en | input | 1 | One dot of time passes on this cycle |
| lcd_on | input | 1 | LCD enable; when low, counters are cleared and held |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = status, 1 = compare line |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| line_cnt | output | 8 | Current line number |
| mode | output | 2 | Current display mode |
| vram_block | output | 1 | CPU access to video RAM blocked |
| oam_block | output | 1 | CPU access to sprite attribute RAM blocked |
| stat_irq | output | 1 | Status interrupt request pulse |

## Verification
The bench targets the dot boundaries 79/80, 251/252 and 455/0, and the line boundaries 143/144 and 153/0. If a window is off by one dot, the mode mismatches on exactly that dot. If the frame fails to wrap, line_cnt reads 154.

The bench writes 0xFF to the status register to test its read-only bits. A design that stored the written bits would then read a false mode or a false match flag.

Held enables are used to test the interrupt. A level-sensitive design would hold stat_irq high, and one with a missing edge detect would pulse on every line match.

The bench also switches the LCD off in the middle of a line and back on. A design that kept its counters would then resume mid-line instead of at line 0 in mode 2.

// File: rtl/lms_pkg.sv
package lms_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    MD_HBLANK = 2'd0,
    MD_VBLANK = 2'd1,
    MD_SEARCH = 2'd2,
    MD_XFER   = 2'd3
  } disp_mode_t;

  // Mode for a given dot/line position, from the window lengths.
  function automatic disp_mode_t mode_at(int unsigned dot, int unsigned line,
                                         int unsigned search_dots,
                                         int unsigned xfer_dots,
                                         int unsigned vis_lines);
    if (line >= vis_lines)                return MD_VBLANK;
    if (dot < search_dots)                return MD_SEARCH;
    if (dot < search_dots + xfer_dots)    return MD_XFER;
    return MD_HBLANK;
  endfunction

  // Status read image: fixed one, enables, match flag, live mode.
  function automatic logic [REG_W-1:0] status_image(logic [3:0] en, logic match,
                                                    disp_mode_t md);
    return {1'b1, en, match, md};
  endfunction

endpackage

// File: rtl/lms_dot_timer.sv
module lms_dot_timer #(
  parameter int DOTS_PER_LINE = 456,
  parameter int LINES_PER_FRAME = 154,
  parameter int LINE_W = 8,
  localparam int DOT_W = $clog2(DOTS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic              line_last_dot,
  output logic              frame_last_dot
);

  localparam logic [DOT_W-1:0]  DOT_MAX  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_MAX = LINE_W'(LINES_PER_FRAME - 1);

  assign line_last_dot  = (dot == DOT_MAX);
  assign frame_last_dot = line_last_dot && (line == LINE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (!run) begin
      dot  <= '0;
      line <= '0;
    end else if (step) begin
      if (line_last_dot) begin
        dot  <= '0;
        line <= frame_last_dot ? '0 : line + 1'b1;
      end else begin
        dot <= dot + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lms_mode_decode.sv
module lms_mode_decode
  import lms_pkg::*;
#(
  parameter int SEARCH_DOTS = 80,
  parameter int XFER_DOTS = 172,
  parameter int VISIBLE_LINES = 144,
  parameter int DOT_W = 9,
  parameter int LINE_W = 8
) (
  input  logic              run,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output disp_mode_t        cur_mode,
  output logic              vram_lock,
  output logic              oam_lock
);

  always_comb begin
    if (run)
      cur_mode = mode_at(int'(dot), int'(line), SEARCH_DOTS, XFER_DOTS, VISIBLE_LINES);
    else
      cur_mode = MD_HBLANK;
  end

  assign vram_lock = (cur_mode == MD_XFER);
  assign oam_lock  = (cur_mode == MD_XFER) || (cur_mode == MD_SEARCH);

endmodule

// File: rtl/lms_status_reg.sv
module lms_status_reg
  import lms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  disp_mode_t       cur_mode,
  input  logic [REG_W-1:0] line,
  output logic [REG_W-1:0] rdata,
  output logic             line_match,
  output logic             irq_cond,
  output logic             irq_pulse
);

  logic [3:0]       enables;   // {match, search, vblank, hblank}
  logic [REG_W-1:0] cmp_line;
  logic             cond_q;

  assign line_match = (line == cmp_line);

  always_comb begin
    irq_cond = 1'b0;
    unique case (cur_mode)
      MD_HBLANK: irq_cond = enables[0];
      MD_VBLANK: irq_cond = enables[1];
      MD_SEARCH: irq_cond = enables[2];
      default:   irq_cond = 1'b0;
    endcase
    irq_cond = irq_cond | (line_match & enables[3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enables   <= '0;
      cmp_line  <= '0;
      cond_q    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      cond_q    <= irq_cond;
      irq_pulse <= irq_cond & ~cond_q;
      if (we) begin
        if (sel) cmp_line <= wdata;
        else     enables  <= wdata[6:3];
      end
    end
  end

  assign rdata = sel ? cmp_line : status_image(enables, line_match, cur_mode);

endmodule

// File: rtl/lms_mode_seq.sv
module lms_mode_seq
  import lms_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int SEARCH_DOTS = 80,
  parameter int XFER_DOTS = 172,
  parameter int VISIBLE_LINES = 144,
  parameter int LINES_PER_FRAME = 154
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dot_en,
  input  logic             lcd_on,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] line_cnt,
  output logic [1:0]       mode,
  output logic             vram_block,
  output logic             oam_block,
  output logic             stat_irq
);

  localparam int DOT_W = $clog2(DOTS_PER_LINE);

  logic [DOT_W-1:0] dot_cnt;
  logic             line_end;
  logic             frame_end;
  disp_mode_t       cur_mode;
  logic             line_match;
  logic             irq_cond;

  lms_dot_timer #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .LINE_W(REG_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(lcd_on), .step(dot_en),
    .dot(dot_cnt), .line(line_cnt),
    .line_last_dot(line_end), .frame_last_dot(frame_end)
  );

  lms_mode_decode #(
    .SEARCH_DOTS(SEARCH_DOTS), .XFER_DOTS(XFER_DOTS),
    .VISIBLE_LINES(VISIBLE_LINES), .DOT_W(DOT_W), .LINE_W(REG_W)
  ) u_decode (
    .run(lcd_on), .dot(dot_cnt), .line(line_cnt),
    .cur_mode(cur_mode), .vram_lock(vram_block), .oam_lock(oam_block)
  );

  lms_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .cur_mode(cur_mode), .line(line_cnt), .rdata(reg_rdata),
    .line_match(line_match), .irq_cond(irq_cond), .irq_pulse(stat_irq)
  );

  assign mode = cur_mode;

endmodule

// File: rtl/lms_mode_seq_chk.sv
module lms_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lcd_on,
  input logic       dot_en,
  input logic       reg_sel,
  input logic [7:0] reg_rdata,
  input logic [7:0] line_cnt,
  input logic [1:0] mode,
  input logic       vram_block,
  input logic       oam_block,
  input logic       stat_irq,
  input logic       line_end,
  input logic       frame_end
);

  assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= 8'd153);

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && dot_en && frame_end) |=> (line_cnt == 8'd0));

  assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> (line_cnt == 8'd0));

  assert_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |-> (mode == 2'd0 && !vram_block && !oam_block));

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && !$past(lcd_on)) |-> (mode == 2'd2 && line_cnt == 8'd0));

  assert_mode_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && $past(lcd_on) && mode != $past(mode)) |->
      (($past(mode) == 2'd2 && mode == 2'd3) ||
       ($past(mode) == 2'd3 && mode == 2'd0) ||
       ($past(mode) == 2'd0 && (mode == 2'd2 || mode == 2'd1)) ||
       ($past(mode) == 2'd1 && mode == 2'd2)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && !dot_en) |=> $stable(line_cnt));

  assert_vram_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vram_block |-> (oam_block && reg_sel == 1'b0 -> reg_rdata[1:0] == 2'd3));

  assert_bit7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 1'b0) |-> reg_rdata[7]);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |=> !stat_irq);

  assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && dot_en && line_end && !frame_end) |=> (line_cnt == $past(line_cnt) + 8'd1));

endmodule

bind lms_mode_seq lms_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .dot_en(dot_en),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .line_cnt(line_cnt), .mode(mode),
  .vram_block(vram_block), .oam_block(oam_block), .stat_irq(stat_irq),
  .line_end(line_end), .frame_end(frame_end)
);

// File: tb/tb_lms_mode_seq.sv
`timescale 1ns/1ps
module tb_lms_mode_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dot_en = 1'b0;
  logic       lcd_on = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] line_cnt;
  logic [1:0] mode;
  logic       vram_block, oam_block, stat_irq;

  always #10 clk = ~clk;   // 50 MHz

  lms_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .lcd_on(lcd_on),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .line_cnt(line_cnt), .mode(mode),
    .vram_block(vram_block), .oam_block(oam_block), .stat_irq(stat_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference state
  int         m_dot = 0, m_line = 0;
  logic [3:0] m_en = 4'h0;
  logic [7:0] m_cmp = 8'h00;
  logic       m_cq = 1'b0, m_irq = 1'b0;

  function automatic int exp_mode();
    if (!lcd_on) return 0;
    if (m_line >= 144) return 1;
    if (m_dot < 80) return 2;
    if (m_dot < 80 + 172) return 3;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      if (n_bad < 30)
        $display("FAIL %s: actual %0d expected %0d (line %0d dot %0d)", tag, act, exp, m_line, m_dot);
    end
  endtask

  function automatic bit exp_cond();
    int md = exp_mode();
    bit c = (md == 0 && m_en[0]) || (md == 1 && m_en[1]) || (md == 2 && m_en[2]);
    return c || ((m_line[7:0] == m_cmp) && m_en[3]);
  endfunction

  // One clock: advance the reference at the edge, compare mid-cycle.
  task automatic cyc();
    bit c;
    @(posedge clk);
    c = exp_cond();
    m_irq = c & ~m_cq;
    m_cq = c;
    if (!lcd_on) begin
      m_dot = 0; m_line = 0;
    end else if (dot_en) begin
      if (m_dot == 455) begin
        m_dot = 0;
        m_line = (m_line == 153) ? 0 : m_line + 1;
      end else m_dot++;
    end
    if (reg_we) begin
      if (reg_sel) m_cmp = reg_wdata;
      else         m_en = reg_wdata[6:3];
    end
    @(negedge clk);
    begin
      int md = exp_mode();
      string mtag = !lcd_on ? "R8" : (m_line >= 144 ? "R2" : "R1");
      chk(mtag, int'(mode), md);
      chk(dot_en ? "R2" : "R10", int'(line_cnt), m_line);
      chk("R6 oam", int'(oam_block), (md == 2 || md == 3) ? 1 : 0);
      chk("R6 vram", int'(vram_block), (md == 3) ? 1 : 0);
      chk("R9", int'(stat_irq), int'(m_irq));
      if (!reg_sel) begin
        chk("R3", int'(reg_rdata[1:0]), md);
        chk("R4", int'(reg_rdata[2]), (m_line[7:0] == m_cmp) ? 1 : 0);
        chk("R5", int'(reg_rdata[7:3]), int'({1'b1, m_en}));
      end else begin
        chk("R11", int'(reg_rdata), int'(m_cmp));
      end
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_we = 1'b0; reg_sel = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // Reset state: LCD off, line 0, compare 0 -> 0x84
    chk("R5 reset", int'(reg_rdata), 8'h84);
    chk("R8 reset", int'(line_cnt), 0);
    rst_n = 1'b1;
    repeat (10) cyc();

    // R5: try to set every bit; only 6:3 stick, live bits unaffected
    wr(1'b0, 8'hFF);
    chk("R5 write", int'(reg_rdata), 8'hFC);
    // R11: compare line readback
    wr(1'b1, 8'd5);
    reg_sel = 1'b1; cyc(); chk("R11", int'(reg_rdata), 5); reg_sel = 1'b0;
    // Enable hblank and line-match interrupts only
    wr(1'b0, 8'h48);

    // R7: turn on, first cycle at line 0 mode 2
    lcd_on = 1'b1; dot_en = 1'b1;
    #1 chk("R7", int'(mode), 2);
    chk("R7 line", int'(line_cnt), 0);
    // One full frame plus a few lines: covers R1, R2 wrap, R9
    for (int i = 0; i < 456 * 154 + 1500; i++) cyc();

    // R10: dot enable every third cycle, vblank + search interrupts
    wr(1'b0, 8'h30);
    wr(1'b1, 8'd150);
    for (int i = 0; i < 9000; i++) begin
      dot_en = (i % 3 == 0);
      cyc();
    end
    dot_en = 1'b1;
    for (int i = 0; i < 456 * 150; i++) cyc();

    // R8: switch off mid-line, hold, then R7 restart
    lcd_on = 1'b0;
    for (int i = 0; i < 50; i++) cyc();
    chk("R8 off", int'(line_cnt), 0);
    lcd_on = 1'b1;
    #1 chk("R7 restart", int'(mode), 2);
    for (int i = 0; i < 600; i++) cyc();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule